// File: doc/BRIEF.md
# Video Test Source Frame Control

This block sits beside a video test pattern source. It holds the run-time settings in a small file of 16-bit registers that a memory-mapped port can reach. It also decides when each frame and field of the source begins. Software writes the following settings at any time: the output size, the interlace standard, the pattern number, the three fill-colour samples and a border enable. The generator never sees a setting change part way through a frame. At a frame boundary, the sequencer copies the live settings into a shadow set, but only when the Go bit allows it. It then announces each field with a valid/ready header strobe that carries the shadowed parameters. After that it waits for the generator to report that the field is finished.

An interlaced frame is sampled once and produces two headers, one per field. The field identity alternates, and the first field follows the selected standard. Each field header carries half of the progressive height. A status bit tells software whether a frame is in progress and so can no longer be held back by clearing Go.

Top module: `vidgen_ctrl`

## Requirements
- R1: Register words are at these addresses: 4 width, 5 height, 6 interlace mode (2 bits), 7 pattern select, 8 R/Y, 9 G/Cb and 10 B/Cr. A write to one of these addresses is visible when that address is read on the following cycle.
- R2: Address 0 is the control word, with Go in bit 0 and the border enable in bit 1. Its other bits always read as zero.
- R3: With the default build (run-time control enabled), Go and the border enable both reset to 0. The width resets to 640, the height to 480, and the mode, pattern and colours to 0.
- R4: While Go reads 0 at a frame boundary, no field header is issued and no frame starts.
- R5: The header payload comes from a shadow copy taken in the cycle a frame starts. Writes made during a frame change only later frames. The payload is held steady while the header is waiting for ready.
- R6: Status (address 1, bit 0) reads 1 from the cycle after a frame starts until the cycle after its last field-done. It reads 0 while the sequencer is idle.
- R7: Interlace modes are 0 progressive, 1 interlaced with the first field F0 (field output 0), 2 interlaced with the first field F1 (field output 1), and 3 progressive.
- R8: An interlaced frame issues exactly two headers with opposite field values, both from a single sampling. A progressive frame issues exactly one header.
- R9: A write to width or height is clamped to the range 32 up to MAX_WIDTH or MAX_HEIGHT (defaults 1920 and 1080).
- R10: Writes to addresses 1, 2, 3 and 11 to 15 have no effect. Reads of 2, 3 and 11 to 15 return zero.
- R11: A header stays valid until ready is seen. A field-done pulse is heeded only after the header has been accepted.
- R12: The header height of an interlaced field is ceil(H/2) for F0 and floor(H/2) for F1. A progressive header carries H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| fs_valid | output | 1 | Field header valid |
| fs_ready | input | 1 | Generator accepts the header |
| fs_field | output | 1 | Field identity, 0 = F0, 1 = F1 |
| fs_interlaced | output | 1 | Frame is interlaced |
| fs_width | output | 16 | Shadowed width |
| fs_height | output | 16 | Height for this field |
| fs_pattern | output | 16 | Shadowed pattern select |
| fs_border | output | 1 | Shadowed border enable |
| fs_c0 | output | 16 | Shadowed R/Y sample |
| fs_c1 | output | 16 | Shadowed G/Cb sample |
| fs_c2 | output | 16 | Shadowed B/Cr sample |
| field_done | input | 1 | Generator finished the current field |

## Verification
The hardest case to reach is a register write that lands in the very cycle the sequencer samples the settings. In that case the shadow must take the old value, and the new value must appear only on the next frame. The stimulus writes width, height and mode on every few cycles while frames run back to back. The generator side pulses ready and field-done at random, so such writes fall on frame starts, between the two fields of an interlaced frame, and while a header is stalled. Field-done pulses that arrive while a header is still pending also test R11.

// File: rtl/vgc_pkg.sv
`timescale 1ns/1ps
package vgc_pkg;
    localparam int DW = 16;
    localparam int AW = 4;

    localparam logic [AW-1:0] A_CTRL   = 4'd0;
    localparam logic [AW-1:0] A_STAT   = 4'd1;
    localparam logic [AW-1:0] A_WIDTH  = 4'd4;
    localparam logic [AW-1:0] A_HEIGHT = 4'd5;
    localparam logic [AW-1:0] A_MODE   = 4'd6;
    localparam logic [AW-1:0] A_PAT    = 4'd7;
    localparam logic [AW-1:0] A_C0     = 4'd8;
    localparam logic [AW-1:0] A_C1     = 4'd9;
    localparam logic [AW-1:0] A_C2     = 4'd10;

    localparam logic [1:0] MODE_F0_FIRST = 2'd1;
    localparam logic [1:0] MODE_F1_FIRST = 2'd2;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_HDR  = 2'd1,
        SQ_WAIT = 2'd2
    } seq_st_e;

    typedef struct packed {
        logic          border;
        logic [DW-1:0] width;
        logic [DW-1:0] height;
        logic [1:0]    mode;
        logic [DW-1:0] pattern;
        logic [DW-1:0] c0;
        logic [DW-1:0] c1;
        logic [DW-1:0] c2;
    } frame_cfg_t;
endpackage

// File: rtl/vgc_regfile.sv
`timescale 1ns/1ps
module vgc_regfile
    import vgc_pkg::*;
#(
    parameter int MIN_DIM      = 32,
    parameter int MAX_WIDTH    = 1920,
    parameter int MAX_HEIGHT   = 1080,
    parameter int DEF_WIDTH    = 640,
    parameter int DEF_HEIGHT   = 480,
    parameter bit RUNTIME_CTRL = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          go,
    output frame_cfg_t    live
);
    localparam logic [DW-1:0] LO_DIM  = DW'(MIN_DIM);
    localparam logic [DW-1:0] HI_W    = DW'(MAX_WIDTH);
    localparam logic [DW-1:0] HI_H    = DW'(MAX_HEIGHT);
    localparam logic          GO_INIT = RUNTIME_CTRL ? 1'b0 : 1'b1;

    typedef struct packed {
        logic       go;
        frame_cfg_t cfg;
    } regs_t;

    regs_t r_d, r_q;

    function automatic logic [DW-1:0] clamp_dim(input logic [DW-1:0] v,
                                                input logic [DW-1:0] hi);
        if (v < LO_DIM) return LO_DIM;
        if (v > hi)     return hi;
        return v;
    endfunction

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            unique case (addr)
                A_CTRL: begin
                    r_d.go         = wdata[0];
                    r_d.cfg.border = wdata[1];
                end
                A_WIDTH:  r_d.cfg.width   = clamp_dim(wdata, HI_W);
                A_HEIGHT: r_d.cfg.height  = clamp_dim(wdata, HI_H);
                A_MODE:   r_d.cfg.mode    = wdata[1:0];
                A_PAT:    r_d.cfg.pattern = wdata;
                A_C0:     r_d.cfg.c0      = wdata;
                A_C1:     r_d.cfg.c1      = wdata;
                A_C2:     r_d.cfg.c2      = wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.go          <= GO_INIT;
            r_q.cfg.border  <= 1'b0;
            r_q.cfg.width   <= DW'(DEF_WIDTH);
            r_q.cfg.height  <= DW'(DEF_HEIGHT);
            r_q.cfg.mode    <= 2'd0;
            r_q.cfg.pattern <= '0;
            r_q.cfg.c0      <= '0;
            r_q.cfg.c1      <= '0;
            r_q.cfg.c2      <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign go   = r_q.go;
    assign live = r_q.cfg;
endmodule

// File: rtl/vgc_readmux.sv
`timescale 1ns/1ps
module vgc_readmux
    import vgc_pkg::*;
(
    input  logic [AW-1:0] addr,
    input  logic          go,
    input  logic          busy,
    input  frame_cfg_t    live,
    output logic [DW-1:0] rdata
);
    always_comb begin
        rdata = '0;
        unique case (addr)
            A_CTRL:   rdata = {{(DW-2){1'b0}}, live.border, go};
            A_STAT:   rdata = {{(DW-1){1'b0}}, busy};
            A_WIDTH:  rdata = live.width;
            A_HEIGHT: rdata = live.height;
            A_MODE:   rdata = {{(DW-2){1'b0}}, live.mode};
            A_PAT:    rdata = live.pattern;
            A_C0:     rdata = live.c0;
            A_C1:     rdata = live.c1;
            A_C2:     rdata = live.c2;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/vgc_sequencer.sv
`timescale 1ns/1ps
module vgc_sequencer
    import vgc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  frame_cfg_t    live,
    input  logic          fs_ready,
    input  logic          field_done,
    output logic          fs_valid,
    output logic          fs_field,
    output logic          fs_interlaced,
    output logic [DW-1:0] fs_width,
    output logic [DW-1:0] fs_height,
    output logic [DW-1:0] fs_pattern,
    output logic          fs_border,
    output logic [DW-1:0] fs_c0,
    output logic [DW-1:0] fs_c1,
    output logic [DW-1:0] fs_c2,
    output logic          busy
);
    typedef struct packed {
        seq_st_e    st;
        logic       field;
        logic       second;
        frame_cfg_t sh;
    } seq_t;

    seq_t s_d, s_q;
    logic il_q;
    logic [DW:0]   h_plus1;
    logic [DW-1:0] h_ceil, h_floor;

    assign il_q = (s_q.sh.mode == MODE_F0_FIRST) || (s_q.sh.mode == MODE_F1_FIRST);

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            SQ_IDLE: begin
                if (go) begin
                    s_d.sh     = live;
                    s_d.field  = (live.mode == MODE_F1_FIRST);
                    s_d.second = 1'b0;
                    s_d.st     = SQ_HDR;
                end
            end
            SQ_HDR: begin
                if (fs_ready) s_d.st = SQ_WAIT;
            end
            SQ_WAIT: begin
                if (field_done) begin
                    if (il_q && !s_q.second) begin
                        s_d.second = 1'b1;
                        s_d.field  = ~s_q.field;
                        s_d.st     = SQ_HDR;
                    end else begin
                        s_d.st = SQ_IDLE;
                    end
                end
            end
            default: s_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st     <= SQ_IDLE;
            s_q.field  <= 1'b0;
            s_q.second <= 1'b0;
            s_q.sh     <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign h_plus1 = {1'b0, s_q.sh.height} + {{DW{1'b0}}, 1'b1};
    assign h_ceil  = h_plus1[DW:1];
    assign h_floor = {1'b0, s_q.sh.height[DW-1:1]};

    assign fs_valid      = (s_q.st == SQ_HDR);
    assign busy          = (s_q.st != SQ_IDLE);
    assign fs_field      = s_q.field;
    assign fs_interlaced = il_q;
    assign fs_width      = s_q.sh.width;
    assign fs_height     = !il_q ? s_q.sh.height : (s_q.field ? h_floor : h_ceil);
    assign fs_pattern    = s_q.sh.pattern;
    assign fs_border     = s_q.sh.border;
    assign fs_c0         = s_q.sh.c0;
    assign fs_c1         = s_q.sh.c1;
    assign fs_c2         = s_q.sh.c2;
endmodule

// File: rtl/vidgen_ctrl.sv
`timescale 1ns/1ps
module vidgen_ctrl
    import vgc_pkg::*;
#(
    parameter int MIN_DIM      = 32,
    parameter int MAX_WIDTH    = 1920,
    parameter int MAX_HEIGHT   = 1080,
    parameter int DEF_WIDTH    = 640,
    parameter int DEF_HEIGHT   = 480,
    parameter bit RUNTIME_CTRL = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [3:0]    bus_addr,
    input  logic [15:0]   bus_wdata,
    output logic [15:0]   bus_rdata,
    output logic          fs_valid,
    input  logic          fs_ready,
    output logic          fs_field,
    output logic          fs_interlaced,
    output logic [15:0]   fs_width,
    output logic [15:0]   fs_height,
    output logic [15:0]   fs_pattern,
    output logic          fs_border,
    output logic [15:0]   fs_c0,
    output logic [15:0]   fs_c1,
    output logic [15:0]   fs_c2,
    input  logic          field_done
);
    logic       go_w;
    logic       busy_w;
    frame_cfg_t live_w;

    vgc_regfile #(
        .MIN_DIM(MIN_DIM), .MAX_WIDTH(MAX_WIDTH), .MAX_HEIGHT(MAX_HEIGHT),
        .DEF_WIDTH(DEF_WIDTH), .DEF_HEIGHT(DEF_HEIGHT), .RUNTIME_CTRL(RUNTIME_CTRL)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .go(go_w), .live(live_w)
    );

    vgc_readmux u_rmux (
        .addr(bus_addr), .go(go_w), .busy(busy_w), .live(live_w), .rdata(bus_rdata)
    );

    vgc_sequencer u_seq (
        .clk(clk), .rst_n(rst_n), .go(go_w), .live(live_w),
        .fs_ready(fs_ready), .field_done(field_done),
        .fs_valid(fs_valid), .fs_field(fs_field), .fs_interlaced(fs_interlaced),
        .fs_width(fs_width), .fs_height(fs_height), .fs_pattern(fs_pattern),
        .fs_border(fs_border), .fs_c0(fs_c0), .fs_c1(fs_c1), .fs_c2(fs_c2),
        .busy(busy_w)
    );
endmodule

// File: rtl/vgc_checker.sv
`timescale 1ns/1ps
module vgc_checker #(
    parameter int MIN_DIM    = 32,
    parameter int MAX_WIDTH  = 1920,
    parameter int MAX_HEIGHT = 1080
) (
    input logic        clk,
    input logic        rst_n,
    input logic        fs_valid,
    input logic        fs_ready,
    input logic        fs_field,
    input logic        fs_interlaced,
    input logic [15:0] fs_width,
    input logic [15:0] fs_height,
    input logic        busy,
    input logic        go
);
    localparam logic [15:0] LO_DIM   = 16'(MIN_DIM);
    localparam logic [15:0] HI_W     = 16'(MAX_WIDTH);
    localparam logic [15:0] HALF_MAX = 16'((MAX_HEIGHT + 1) / 2);

    p_hold_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fs_valid && !fs_ready |=> fs_valid);

    p_payload_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fs_valid && !fs_ready |=> $stable(fs_width) && $stable(fs_height) && $stable(fs_field));

    p_width_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fs_valid |-> (fs_width >= LO_DIM) && (fs_width <= HI_W));

    p_busy_in_header_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fs_valid |-> busy);

    p_go_gates_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(go));

    p_field_half_r12: assert property (@(posedge clk) disable iff (!rst_n)
        fs_valid && fs_interlaced |-> fs_height <= HALF_MAX);
endmodule

bind vidgen_ctrl vgc_checker #(
    .MIN_DIM(MIN_DIM), .MAX_WIDTH(MAX_WIDTH), .MAX_HEIGHT(MAX_HEIGHT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .fs_valid(fs_valid), .fs_ready(fs_ready),
    .fs_field(fs_field), .fs_interlaced(fs_interlaced), .fs_width(fs_width),
    .fs_height(fs_height), .busy(busy_w), .go(go_w)
);

// File: tb/sim_vidgen_ctrl.sv
`timescale 1ns/1ps
module sim_vidgen_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        fs_valid, fs_field, fs_interlaced, fs_border;
    logic        fs_ready = 1'b0;
    logic        field_done = 1'b0;
    logic [15:0] fs_width, fs_height, fs_pattern, fs_c0, fs_c1, fs_c2;

    int n_cmp = 0;
    int n_bad = 0;
    bit sink_en = 1'b0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    vidgen_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fs_valid(fs_valid),
        .fs_ready(fs_ready), .fs_field(fs_field), .fs_interlaced(fs_interlaced),
        .fs_width(fs_width), .fs_height(fs_height), .fs_pattern(fs_pattern),
        .fs_border(fs_border), .fs_c0(fs_c0), .fs_c1(fs_c1), .fs_c2(fs_c2),
        .field_done(field_done)
    );

    // behavioural reference model
    int m_go, m_border, m_w, m_h, m_mode, m_pat, m_c0, m_c1, m_c2;
    int m_st;            // 0 idle, 1 header pending, 2 field running
    int s_border, s_w, s_h, s_mode, s_pat, s_c0, s_c1, s_c2;
    int m_field, m_second, m_hdrs;

    function automatic int fit(int v, int hi);
        if (v < 32) return 32;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic bit is_il(int md);
        return (md == 1) || (md == 2);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_go = 0; m_border = 0; m_w = 640; m_h = 480; m_mode = 0;
            m_pat = 0; m_c0 = 0; m_c1 = 0; m_c2 = 0;
            m_st = 0; m_field = 0; m_second = 0; m_hdrs = 0;
        end else begin
            case (m_st)
                0: if (m_go != 0) begin
                    s_border = m_border; s_w = m_w; s_h = m_h; s_mode = m_mode;
                    s_pat = m_pat; s_c0 = m_c0; s_c1 = m_c1; s_c2 = m_c2;
                    m_field = (m_mode == 2) ? 1 : 0;
                    m_second = 0; m_st = 1;
                end
                1: if (fs_ready) begin m_st = 2; m_hdrs++; end
                default: if (field_done) begin
                    if (is_il(s_mode) && m_second == 0) begin
                        m_second = 1; m_field = 1 - m_field; m_st = 1;
                    end else m_st = 0;
                end
            endcase
            if (bus_wr) begin
                case (int'(bus_addr))
                    0: begin m_go = int'(bus_wdata[0]); m_border = int'(bus_wdata[1]); end
                    4: m_w = fit(int'(bus_wdata), 1920);
                    5: m_h = fit(int'(bus_wdata), 1080);
                    6: m_mode = int'(bus_wdata[1:0]);
                    7: m_pat = int'(bus_wdata);
                    8: m_c0 = int'(bus_wdata);
                    9: m_c1 = int'(bus_wdata);
                    10: m_c2 = int'(bus_wdata);
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_rd(int a);
        case (a)
            0: return m_go + 2 * m_border;
            1: return (m_st != 0) ? 1 : 0;
            4: return m_w;
            5: return m_h;
            6: return m_mode;
            7: return m_pat;
            8: return m_c0;
            9: return m_c1;
            10: return m_c2;
            default: return 0;
        endcase
    endfunction

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            int a, e, eh;
            string tag;
            a = int'(bus_addr);
            e = exp_rd(a);
            case (a)
                0: tag = "R2 control read";
                1: tag = "R6 status read";
                4, 5: tag = "R9 dimension read";
                6, 7, 8, 9, 10: tag = "R1 register read";
                default: tag = "R10 unused read";
            endcase
            chk(int'(bus_rdata) == e, tag, int'(bus_rdata), e);
            chk(fs_valid == (m_st == 1), "R4 R8 R11 header valid", int'(fs_valid), int'(m_st == 1));
            if (m_st == 1 && fs_valid) begin
                eh = !is_il(s_mode) ? s_h : (m_field != 0 ? s_h / 2 : (s_h + 1) / 2);
                chk(int'(fs_field) == m_field, "R7 field id", int'(fs_field), m_field);
                chk(fs_interlaced == is_il(s_mode), "R7 interlace flag", int'(fs_interlaced), int'(is_il(s_mode)));
                chk(int'(fs_height) == eh, "R12 field height", int'(fs_height), eh);
                chk(int'(fs_width) == s_w, "R5 shadow width", int'(fs_width), s_w);
                chk(int'(fs_pattern) == s_pat && int'(fs_border) == s_border,
                    "R5 shadow pattern/border", int'(fs_pattern), s_pat);
                chk(int'(fs_c0) == s_c0 && int'(fs_c1) == s_c1 && int'(fs_c2) == s_c2,
                    "R5 shadow colours", int'(fs_c0), s_c0);
            end
        end
    end

    // generator side: random ready, random field-done (also during headers, R11)
    always @(posedge clk) begin
        #1;
        fs_ready   = sink_en && ($urandom_range(0, 2) != 0);
        field_done = sink_en && ($urandom_range(0, 3) == 0);
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(input int a, input int d);
        bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = 16'(d);
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic sweep(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            bus_addr = 4'(i % 16);
            tick();
        end
    endtask

    // run frames while rewriting settings mid-frame (R5)
    task automatic churn(input int mode, input int cycles);
        wr(6, mode);
        for (int i = 0; i < cycles; i++) begin
            case (i % 7)
                0: wr(4, 40 + (i % 300));
                2: wr(5, 33 + (i % 97));
                4: wr(7, i);
                5: wr(8 + (i % 3), i * 3);
                default: begin bus_addr = 4'(i % 16); tick(); end
            endcase
        end
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R3 reset values
        bus_addr = 4'd0; #2;
        chk(bus_rdata == 16'd0, "R3 reset control", int'(bus_rdata), 0);
        bus_addr = 4'd4; #2;
        chk(bus_rdata == 16'd640, "R3 reset width", int'(bus_rdata), 640);
        tick();
        // R4: Go low, generator active, no frame may start
        sink_en = 1'b1;
        sweep(40);
        // R1 R9 R10 register access
        wr(4, 100); wr(5, 51); wr(6, 1); wr(7, 3);
        wr(8, 16'h1234); wr(9, 16'h00ab); wr(10, 16'hfffe);
        wr(4, 10); bus_addr = 4'd4; tick();
        wr(5, 5000); bus_addr = 4'd5; tick();
        wr(4, 1921); bus_addr = 4'd4; tick();
        wr(4, 100); wr(5, 51);
        wr(1, 16'hffff); wr(2, 16'hffff); wr(3, 16'h5555); wr(12, 16'h7777);
        sweep(32);
        // R2 start frames, extra control bits dropped
        wr(0, 16'hfffd); bus_addr = 4'd0; tick();
        wr(0, 16'hffff);
        sweep(200);
        churn(1, 600);
        churn(2, 600);
        churn(0, 400);
        churn(3, 300);
        wr(6, 1); wr(5, 33);
        sweep(200);
        // R4 stop: Go cleared, frame in progress finishes, then nothing new
        wr(0, 0);
        sweep(400);
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule